// File: doc/BRIEF.md
# Power Event Status and SCI Generator

This block keeps the power-management event status and enable registers, together with a small bank of general-purpose event status and enable bytes. It merges them into one level-sensitive system control interrupt (`sci`). Software reaches both register groups through a single address/data port. One select input picks either the power-management window or the general-purpose window. Hardware sources drive the event inputs: a power-button press, a timer-overflow flag from an external counter, a wake request with a cause code, and a byte of general-purpose event bits.

Status bits stay set until software writes a one to each of them. Enable bits gate which status bits may raise `sci`. The wake flag is recorded in status but never raises `sci` by itself. Only general-purpose byte 0 feeds the interrupt.

Top module: `pm_event_sci`

## Requirements
- R1: After reset, the event status register, the event enable register, every general-purpose status byte and every enable byte read as zero, and `sci` is low.
- R2: A write to power-management offset 0 clears exactly the status bits whose written value is one, inside the byte lanes that `bus_be` enables (bit 0 is the low byte, bit 1 the high byte). All other status bits keep their value.
- R3: A write to power-management offset 2 replaces the enable bits in the enabled byte lanes with the written data. The other lane keeps its value.
- R4: In the power-management window, a read of any offset other than 0 and 2 returns zero, and a write there changes no register.
- R5: A pulse on `ev_pwrbtn` sets status bit 8 (power button) only while enable bit 8 is one.
- R6: A pulse on `wake_req` sets status bit 15 (wake) together with one cause bit. Cause 0 sets bit 10 (RTC), cause 1 sets bit 0 (timer), and causes 2 and 3 set bit 8 (power button).
- R7: A pulse on `tmr_ovf` sets status bit 0.
- R8: `sci` is high in the same cycle the registers hold either of two conditions: (status AND enable AND 0x0721) is non-zero, or (general-purpose status byte 0 AND enable byte 0) is non-zero. Status bit 15 alone never raises `sci`.
- R9: In the general-purpose window, byte addresses below GPE_LEN/2 are status bytes and are write-one-to-clear. Addresses from GPE_LEN/2 up to GPE_LEN-1 are enable bytes and are written plainly. Data uses `bus_wdata[7:0]` and `bus_rdata[7:0]`.
- R10: A cycle with a non-zero `gpe_ev` ORs those bits into general-purpose status byte 0.
- R11: A general-purpose access at address GPE_LEN or above reads zero and changes no byte.
- R12: If an event sets a status bit in the same cycle that software clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gpe | input | 1 | Window select: 0 power-management, 1 general-purpose |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables for power-management writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| ev_pwrbtn | input | 1 | Power-button event pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| wake_req | input | 1 | Wake request pulse |
| wake_cause | input | 2 | Wake cause: 0 RTC, 1 timer, 2/3 other |
| gpe_ev | input | 8 | General-purpose event bits for byte 0 |
| sci | output | 1 | Level system control interrupt |

## Verification
A wrong status or enable bit appears on `sci` or on a read-back in the cycle after the write or event that produced it. There is no hidden state, so every fault becomes visible within one clock. A faulty clear mask or byte-lane decode leaves a bit standing or wipes a neighbour, and the next read of that offset shows it. A wrong address split in the general-purpose bank sends a write to the other half, which shows up both on read-back and on `sci`.

// File: rtl/pm_event_sci.sv
module pm_event_sci #(
  parameter int GPE_LEN = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_gpe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              ev_pwrbtn,
  input  logic              tmr_ovf,
  input  logic              wake_req,
  input  logic [1:0]        wake_cause,
  input  logic [7:0]        gpe_ev,
  output logic              sci
);
  localparam int GPE_HALF = GPE_LEN / 2;
  localparam int B_TMR = 0;
  localparam int B_PWR = 8;
  localparam int B_RTC = 10;
  localparam int B_WAK = 15;
  localparam logic [15:0] SCI_MASK = 16'h0721;

  logic [15:0] pm_sts, pm_en, pm_set, pm_clr, lane;
  logic [GPE_HALF-1:0][7:0] gpe_sts, gpe_en;
  logic hit_sts, hit_en;

  assign hit_sts = bus_wr && !bus_gpe && (bus_addr == ADDR_W'(0));
  assign hit_en  = bus_wr && !bus_gpe && (bus_addr == ADDR_W'(2));
  assign lane    = {{8{bus_be[1]}}, {8{bus_be[0]}}};
  assign pm_clr  = hit_sts ? (bus_wdata & lane) : 16'h0000;

  always_comb begin
    pm_set = 16'h0000;
    pm_set[B_TMR] = tmr_ovf;
    pm_set[B_PWR] = ev_pwrbtn & pm_en[B_PWR];
    if (wake_req) begin
      pm_set[B_WAK] = 1'b1;
      case (wake_cause)
        2'd0:    pm_set[B_RTC] = 1'b1;
        2'd1:    pm_set[B_TMR] = 1'b1;
        default: pm_set[B_PWR] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_sts  <= '0;
      pm_en   <= '0;
      gpe_sts <= '0;
      gpe_en  <= '0;
    end else begin
      pm_sts <= (pm_sts & ~pm_clr) | pm_set;
      if (hit_en) pm_en <= (pm_en & ~lane) | (bus_wdata & lane);
      for (int i = 0; i < GPE_HALF; i++) begin
        gpe_sts[i] <= (gpe_sts[i] &
                       ~((bus_wr && bus_gpe && bus_addr == ADDR_W'(i)) ? bus_wdata[7:0] : 8'h00))
                      | ((i == 0) ? gpe_ev : 8'h00);
        if (bus_wr && bus_gpe && bus_addr == ADDR_W'(GPE_HALF + i))
          gpe_en[i] <= bus_wdata[7:0];
      end
    end
  end

  always_comb begin
    bus_rdata = 16'h0000;
    if (!bus_gpe) begin
      if (bus_addr == ADDR_W'(0)) bus_rdata = pm_sts;
      else if (bus_addr == ADDR_W'(2)) bus_rdata = pm_en;
    end else begin
      for (int i = 0; i < GPE_HALF; i++) begin
        if (bus_addr == ADDR_W'(i)) bus_rdata = {8'h00, gpe_sts[i]};
        if (bus_addr == ADDR_W'(GPE_HALF + i)) bus_rdata = {8'h00, gpe_en[i]};
      end
    end
  end

  assign sci = (|(pm_sts & pm_en & SCI_MASK)) || (|(gpe_sts[0] & gpe_en[0]));

  p_pwr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pwrbtn && pm_en[B_PWR]) |=> pm_sts[B_PWR]);
  p_wake_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> pm_sts[B_WAK]);
  p_tmr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> pm_sts[B_TMR]);
  p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_gpe && bus_addr == ADDR_W'(2) && bus_be == 2'b11) |=> pm_en == $past(bus_wdata));
  p_gpe_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gpe_ev != 8'h00) |=> ((gpe_sts[0] & $past(gpe_ev)) == $past(gpe_ev)));
  p_gpe_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_gpe && bus_addr == ADDR_W'(GPE_HALF)) |=> gpe_en[0] == $past(bus_wdata[7:0]));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_en == 16'h0000 && gpe_en[0] == 8'h00) |-> !sci);
endmodule

// File: tb/sim_pm_event_sci.sv
module sim_pm_event_sci;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_gpe = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic ev_pwrbtn = 0, tmr_ovf = 0, wake_req = 0;
  logic [1:0] wake_cause = 0;
  logic [7:0] gpe_ev = 0;
  logic sci;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_event_sci u0 (.clk(clk), .rst_n(rst_n), .bus_gpe(bus_gpe), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pwrbtn(ev_pwrbtn), .tmr_ovf(tmr_ovf), .wake_req(wake_req),
    .wake_cause(wake_cause), .gpe_ev(gpe_ev), .sci(sci));

  typedef struct { bit kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic chk_on = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (chk_on && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = it.kind ? {15'h0, sci} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic pm_wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_gpe = 0; bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    tick(); bus_wr = 0;
  endtask

  task automatic gp_wr(input logic [7:0] a, input logic [7:0] d);
    bus_gpe = 1; bus_addr = a; bus_be = 2'b01; bus_wdata = {8'h00, d}; bus_wr = 1;
    tick(); bus_wr = 0;
  endtask

  task automatic exp_rd(input logic g, input logic [7:0] a, input logic [15:0] e, input string tag);
    q.push_back('{1'b0, e, tag});
    bus_gpe = g; bus_addr = a; chk_on = 1;
    tick(); chk_on = 0;
  endtask

  task automatic exp_sci(input logic e, input string tag);
    q.push_back('{1'b1, {15'h0, e}, tag});
    chk_on = 1;
    tick(); chk_on = 0;
  endtask

  task automatic wake(input logic [1:0] c);
    wake_req = 1; wake_cause = c; tick(); wake_req = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    exp_rd(0, 0, 16'h0000, "R1 status");
    exp_rd(0, 2, 16'h0000, "R1 enable");
    exp_rd(1, 0, 16'h0000, "R1 gpe sts0");
    exp_rd(1, 3, 16'h0000, "R1 gpe en1");
    exp_sci(0, "R1 sci");

    pm_wr(2, 2'b11, 16'h0100);
    exp_rd(0, 2, 16'h0100, "R3 full write");
    pm_wr(2, 2'b01, 16'hAB21);
    exp_rd(0, 2, 16'h0121, "R3 low lane");
    ev_pwrbtn = 1; tick(); ev_pwrbtn = 0;
    exp_rd(0, 0, 16'h0100, "R5 enabled press");
    exp_sci(1, "R8 pwrbtn");
    pm_wr(2, 2'b11, 16'h0000);
    exp_sci(0, "R8 masked");
    pm_wr(0, 2'b11, 16'h0100);
    exp_rd(0, 0, 16'h0000, "R2 clear");
    ev_pwrbtn = 1; tick(); ev_pwrbtn = 0;
    exp_rd(0, 0, 16'h0000, "R5 gated press");

    wake(2'd0);
    exp_rd(0, 0, 16'h8400, "R6 rtc");
    wake(2'd1);
    exp_rd(0, 0, 16'h8401, "R6 timer");
    pm_wr(0, 2'b11, 16'h0001);
    exp_rd(0, 0, 16'h8400, "R2 single bit");
    pm_wr(0, 2'b01, 16'hFFFF);
    exp_rd(0, 0, 16'h8400, "R2 lane off");
    pm_wr(0, 2'b10, 16'h8000);
    exp_rd(0, 0, 16'h0400, "R2 high lane");
    wake(2'd2);
    exp_rd(0, 0, 16'h8500, "R6 other");
    pm_wr(0, 2'b11, 16'hFFFF);
    wake(2'd3);
    exp_rd(0, 0, 16'h8100, "R6 other 3");
    pm_wr(0, 2'b11, 16'hFFFF);
    exp_rd(0, 0, 16'h0000, "R2 clear all");

    tmr_ovf = 1; tick(); tmr_ovf = 0;
    exp_rd(0, 0, 16'h0001, "R7 timer");
    exp_sci(0, "R8 timer not enabled");
    pm_wr(2, 2'b11, 16'h0001);
    exp_sci(1, "R8 timer enabled");
    pm_wr(0, 2'b11, 16'hFFFF);
    wake(2'd0);
    pm_wr(2, 2'b11, 16'h8000);
    exp_sci(0, "R8 wake bit alone");
    pm_wr(0, 2'b11, 16'hFFFF);

    tmr_ovf = 1; pm_wr(0, 2'b11, 16'h0001); tmr_ovf = 0;
    exp_rd(0, 0, 16'h0001, "R12 set wins");
    pm_wr(0, 2'b11, 16'hFFFF);

    pm_wr(2, 2'b11, 16'h0421);
    exp_rd(0, 1, 16'h0000, "R4 offset 1");
    exp_rd(0, 3, 16'h0000, "R4 offset 3");
    exp_rd(0, 4, 16'h0000, "R4 offset 4");
    pm_wr(4, 2'b11, 16'hFFFF);
    exp_rd(0, 2, 16'h0421, "R4 en untouched");
    exp_rd(0, 0, 16'h0000, "R4 sts untouched");

    gp_wr(2, 8'h05);
    exp_rd(1, 2, 16'h0005, "R9 en byte0");
    gpe_ev = 8'h04; tick(); gpe_ev = 0;
    exp_rd(1, 0, 16'h0004, "R10 event");
    exp_sci(1, "R8 gpe");
    gpe_ev = 8'h02; tick(); gpe_ev = 0;
    exp_rd(1, 0, 16'h0006, "R10 or");
    gp_wr(0, 8'h04);
    exp_rd(1, 0, 16'h0002, "R9 w1c");
    exp_sci(0, "R8 gpe masked");
    gp_wr(3, 8'hFF);
    exp_rd(1, 3, 16'h00FF, "R9 en byte1");
    gp_wr(1, 8'hFF);
    exp_rd(1, 1, 16'h0000, "R9 sts byte1 w1c");
    gp_wr(4, 8'hFF);
    exp_rd(1, 4, 16'h0000, "R11 beyond read");
    exp_rd(1, 2, 16'h0005, "R11 en0 kept");
    exp_rd(1, 0, 16'h0002, "R11 sts0 kept");

    tick();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule